// File: doc/BRIEF.md
# Adaptive Low-Side Turn-Off Tracker

This block sets how long the low-side switch of a buck converter stays on when the converter runs in discontinuous conduction. The goal is for the switch to open at the moment the inductor current reaches zero, and to find that moment without an analog comparator. The low-side gate pulse begins one clock after the high-side pulse ends. It stays on for as many clock ticks as an 8-bit step counter holds.

After each low-side turn-off, two delayed strobes each capture a digitized level of the switching node. If both samples are low, the node dipped below ground, so the switch opened too early and the counter steps up. If both samples are high, the node rose above the supply, so the switch opened too late and the counter steps down. A low first sample followed by a high second sample means the timing is right, and the counter holds. The reverse pattern is treated as unusable and is ignored.

Tracking runs on every switching cycle, including after lock. A change in load or conditions therefore moves the count again. A lock flag reports that the hold decision has repeated.

Top module: `zcd_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, `width_o` is 0, `locked_o` is 0 and `ls_gate_o` is 0.
- R2: A decision whose first sample is 0 and second sample is 0 adds one to `width_o`.
- R3: A decision whose first sample is 1 and second sample is 1 subtracts one from `width_o`.
- R4: A decision whose first sample is 0 and second sample is 1 leaves `width_o` unchanged.
- R5: A decision whose first sample is 1 and second sample is 0 changes neither `width_o` nor `locked_o`.
- R6: `width_o` saturates. A step up from 255 stays at 255, and a step down from 0 stays at 0. The count never wraps.
- R7: `locked_o` rises after two consecutive hold decisions (pattern 0 then 1). It stays high through further holds and clears on the next step-up or step-down decision, even one blocked by saturation.
- R8: Once `hs_pulse_i` has been sampled low after being sampled high, `ls_gate_o` rises on the next clock. It then stays high for exactly `width_o` clocks. A count of 0 produces no pulse.
- R9: `ls_gate_o` is never high while `hs_pulse_i` is high. A rising high-side pulse cuts any running low-side pulse short.
- R10: `node_hi_i` is captured as the first sample on a clock where `strobe1_i` is high and as the second sample on a clock where `strobe2_i` is high. The resulting decision appears on `width_o` and `locked_o` two clocks after that `strobe2_i` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hs_pulse_i | input | 1 | High-side gate pulse |
| node_hi_i | input | 1 | Digitized switching-node level |
| strobe1_i | input | 1 | First delayed sampling strobe after low-side turn-off |
| strobe2_i | input | 1 | Second delayed sampling strobe; completes a decision |
| ls_gate_o | output | 1 | Low-side gate pulse |
| width_o | output | 8 | Current low-side on-time, in clock ticks |
| locked_o | output | 1 | High after repeated hold decisions |

## Verification
A wrong count appears on `width_o` two clocks after the second strobe. It then shows up in the length of the very next low-side pulse, so one switching cycle is enough to expose it. A faulty hold-streak register shows up as `locked_o` rising one decision early or late, or surviving a step decision. Wrapping arithmetic only becomes visible at the counter's ends, so the bench drives the count to both saturation limits and then measures a full-length pulse. A timer fault shows up as a pulse one tick too long or too short, or as a low-side pulse overlapping a high-side pulse.

// File: rtl/zcd_pkg.sv
package zcd_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // early: node level at first strobe, late: node level at second strobe
  function automatic step_e classify(input logic early, input logic late);
    step_e res;
    case ({early, late})
      2'b00:   res = STEP_UP;
      2'b11:   res = STEP_DOWN;
      2'b01:   res = STEP_HOLD;
      default: res = STEP_BAD;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/zcd_node_sampler.sv
module zcd_node_sampler
  import zcd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  node_hi_i,
  input  logic  strobe1_i,
  input  logic  strobe2_i,
  output step_e step_o,
  output logic  step_vld_o
);

  logic  first_q, first_d;
  step_e step_q, step_d;
  logic  vld_q, vld_d;

  always_comb begin
    first_d = first_q;
    if (strobe1_i) first_d = node_hi_i;
    step_d = step_q;
    vld_d  = strobe2_i;
    if (strobe2_i) step_d = classify(first_d, node_hi_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      step_q  <= STEP_BAD;
      vld_q   <= 1'b0;
    end else begin
      first_q <= first_d;
      step_q  <= step_d;
      vld_q   <= vld_d;
    end
  end

  assign step_o     = step_q;
  assign step_vld_o = vld_q;

endmodule

// File: rtl/zcd_step_counter.sv
module zcd_step_counter
  import zcd_pkg::*;
#(
  parameter int CW          = 8,
  parameter int RESET_COUNT = 0,
  parameter int LOCK_HOLDS  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_vld_i,
  input  step_e         step_i,
  output logic [CW-1:0] count_o,
  output logic          locked_o
);

  localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};
  localparam logic [CW-1:0] CNT_INIT = CW'(RESET_COUNT);
  localparam int            SW       = $clog2(LOCK_HOLDS + 1);
  localparam logic [SW-1:0] STREAK_TOP = SW'(LOCK_HOLDS);

  logic [CW-1:0] count_q, count_d;
  logic [SW-1:0] streak_q, streak_d;

  always_comb begin
    count_d  = count_q;
    streak_d = streak_q;
    if (step_vld_i) begin
      case (step_i)
        STEP_UP: begin
          if (count_q != CNT_MAX) count_d = count_q + 1'b1;
          streak_d = '0;
        end
        STEP_DOWN: begin
          if (count_q != '0) count_d = count_q - 1'b1;
          streak_d = '0;
        end
        STEP_HOLD: begin
          if (streak_q != STREAK_TOP) streak_d = streak_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= CNT_INIT;
      streak_q <= '0;
    end else begin
      count_q  <= count_d;
      streak_q <= streak_d;
    end
  end

  assign count_o  = count_q;
  assign locked_o = (streak_q == STREAK_TOP);

endmodule

// File: rtl/zcd_lowside_timer.sv
module zcd_lowside_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_i,
  input  logic [CW-1:0] width_i,
  output logic          gate_o
);

  logic          hs_q;
  logic          on_q, on_d;
  logic [CW-1:0] left_q, left_d;
  logic          hs_fall;

  assign hs_fall = hs_q & ~hs_i;

  always_comb begin
    on_d   = on_q;
    left_d = left_q;
    if (hs_i) begin
      on_d   = 1'b0;
      left_d = '0;
    end else if (hs_fall) begin
      on_d   = (width_i != '0);
      left_d = (width_i != '0) ? width_i - 1'b1 : '0;
    end else if (on_q) begin
      if (left_q != '0) left_d = left_q - 1'b1;
      else              on_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      on_q   <= 1'b0;
      left_q <= '0;
    end else begin
      hs_q   <= hs_i;
      on_q   <= on_d;
      left_q <= left_d;
    end
  end

  // mask keeps the switches from overlapping in the cycle hs rises
  assign gate_o = on_q & ~hs_i;

endmodule

// File: rtl/zcd_tracker.sv
module zcd_tracker
  import zcd_pkg::*;
#(
  parameter int CW          = 8,
  parameter int RESET_COUNT = 0,
  parameter int LOCK_HOLDS  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_pulse_i,
  input  logic          node_hi_i,
  input  logic          strobe1_i,
  input  logic          strobe2_i,
  output logic          ls_gate_o,
  output logic [CW-1:0] width_o,
  output logic          locked_o
);

  step_e step_w;
  logic  step_vld_w;

  zcd_node_sampler u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .node_hi_i  (node_hi_i),
    .strobe1_i  (strobe1_i),
    .strobe2_i  (strobe2_i),
    .step_o     (step_w),
    .step_vld_o (step_vld_w)
  );

  zcd_step_counter #(
    .CW          (CW),
    .RESET_COUNT (RESET_COUNT),
    .LOCK_HOLDS  (LOCK_HOLDS)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_vld_i (step_vld_w),
    .step_i     (step_w),
    .count_o    (width_o),
    .locked_o   (locked_o)
  );

  zcd_lowside_timer #(
    .CW (CW)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_i    (hs_pulse_i),
    .width_i (width_o),
    .gate_o  (ls_gate_o)
  );

endmodule

// File: rtl/zcd_tracker_chk.sv
module zcd_tracker_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hs_pulse_i,
  input logic          ls_gate_o,
  input logic [CW-1:0] width_o,
  input logic          locked_o
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_gate_o && hs_pulse_i)); // R9

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (width_o == $past(width_o)) || ({1'b0, width_o} == {1'b0, $past(width_o)} + 1'b1)
    || ({1'b0, $past(width_o)} == {1'b0, width_o} + 1'b1)); // R2

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(($past(width_o) == CNT_MAX && width_o == '0) ||
      ($past(width_o) == '0 && width_o == CNT_MAX))); // R6

  AST_LOCK_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $stable(width_o)); // R7

  AST_GATE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate_o) |-> (!$past(hs_pulse_i) && $past(hs_pulse_i, 2))); // R8

endmodule

bind zcd_tracker zcd_tracker_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hs_pulse_i (hs_pulse_i),
  .ls_gate_o  (ls_gate_o),
  .width_o    (width_o),
  .locked_o   (locked_o)
);

// File: tb/zcd_tracker_tb_top.sv
module zcd_tracker_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 16;

  // [10:9] {first sample, second sample}, [8:1] expected width, [0] expected lock
  localparam logic [10:0] VEC [NVEC] = '{
    {2'b00, 8'd1, 1'b0}, {2'b00, 8'd2, 1'b0}, {2'b00, 8'd3, 1'b0},
    {2'b11, 8'd2, 1'b0}, {2'b01, 8'd2, 1'b0}, {2'b01, 8'd2, 1'b1},
    {2'b10, 8'd2, 1'b1}, {2'b01, 8'd2, 1'b1}, {2'b00, 8'd3, 1'b0},
    {2'b01, 8'd3, 1'b0}, {2'b10, 8'd3, 1'b0}, {2'b01, 8'd3, 1'b1},
    {2'b11, 8'd2, 1'b0}, {2'b11, 8'd1, 1'b0}, {2'b11, 8'd0, 1'b0},
    {2'b11, 8'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hs_pulse_i, node_hi_i, strobe1_i, strobe2_i;
  logic       ls_gate_o, locked_o;
  logic [7:0] width_o;

  int checks = 0;
  int errors = 0;
  int exp_w  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zcd_tracker dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_pulse_i (hs_pulse_i),
    .node_hi_i  (node_hi_i),
    .strobe1_i  (strobe1_i),
    .strobe2_i  (strobe2_i),
    .ls_gate_o  (ls_gate_o),
    .width_o    (width_o),
    .locked_o   (locked_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe_pair(input logic [1:0] pat);
    @(negedge clk); strobe1_i = 1'b1; node_hi_i = pat[1];
    @(negedge clk); strobe1_i = 1'b0; strobe2_i = 1'b1; node_hi_i = pat[0];
    @(negedge clk); strobe2_i = 1'b0; node_hi_i = 1'b0;
    @(negedge clk); // R10: update lands two clocks after strobe2
  endtask

  // one switching period: high-side pulse, measured low-side pulse, strobes
  task automatic run_period(input logic [1:0] pat, input int w_exp);
    int n = 0;
    @(negedge clk); hs_pulse_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(ls_gate_o == 1'b0, "R9 gate low under high side", ls_gate_o, 0);
    end
    hs_pulse_i = 1'b0;
    for (int j = 0; j < w_exp + 3; j++) begin
      @(negedge clk);
      if (j == 0) chk(ls_gate_o == (w_exp != 0), "R8 pulse starts one clock after fall",
                      ls_gate_o, (w_exp != 0));
      if (ls_gate_o) n++;
    end
    chk(n == w_exp, "R8 pulse width", n, w_exp);
    strobe_pair(pat);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hs_pulse_i = 1'b0; node_hi_i = 1'b0;
    strobe1_i = 1'b0; strobe2_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(width_o == 8'd0, "R1 width in reset", width_o, 0);
    chk(locked_o == 1'b0, "R1 lock in reset", locked_o, 0);
    chk(ls_gate_o == 1'b0, "R1 gate in reset", ls_gate_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(width_o == 8'd0, "R1 width after release", width_o, 0);

    // vector walk: R2 R3 R4 R5 R6 R7 R10
    exp_w = 0;
    for (int i = 0; i < NVEC; i++) begin
      run_period(VEC[i][10:9], exp_w);
      chk(width_o == VEC[i][8:1], "R2/R3/R4/R5 width after decision", width_o, VEC[i][8:1]);
      chk(locked_o == VEC[i][0], "R7 lock after decision", locked_o, VEC[i][0]);
      exp_w = VEC[i][8:1];
    end

    // R10: no update before the second clock after strobe2
    @(negedge clk); strobe1_i = 1'b1; node_hi_i = 1'b0;
    @(negedge clk); strobe1_i = 1'b0; strobe2_i = 1'b1; node_hi_i = 1'b0;
    @(negedge clk); strobe2_i = 1'b0;
    chk(width_o == 8'd0, "R10 not yet updated one clock after strobe2", width_o, 0);
    @(negedge clk);
    chk(width_o == 8'd1, "R10 updated two clocks after strobe2", width_o, 1);

    // R6 upper saturation
    for (int k = 0; k < 260; k++) strobe_pair(2'b00);
    chk(width_o == 8'd255, "R6 saturate at 255", width_o, 255);
    strobe_pair(2'b01);
    strobe_pair(2'b01);
    chk(locked_o == 1'b1, "R7 lock at top", locked_o, 1);
    strobe_pair(2'b00);
    chk(width_o == 8'd255, "R6 no wrap past 255", width_o, 255);
    chk(locked_o == 1'b0, "R7 blocked step still clears lock", locked_o, 0);
    run_period(2'b01, 255);
    chk(width_o == 8'd255, "R4 hold at top", width_o, 255);

    // R9 high side rising cuts a running pulse short
    @(negedge clk); hs_pulse_i = 1'b1;
    @(negedge clk); hs_pulse_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(ls_gate_o == 1'b1, "R8 pulse running", ls_gate_o, 1);
    hs_pulse_i = 1'b1;
    #1;
    chk(ls_gate_o == 1'b0, "R9 gate drops as high side rises", ls_gate_o, 0);
    @(negedge clk); hs_pulse_i = 1'b0;
    repeat (260) @(negedge clk);
    chk(ls_gate_o == 1'b0, "R8 pulse ended", ls_gate_o, 0);

    // R1 reset mid-operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(width_o == 8'd0, "R1 width cleared by reset", width_o, 0);
    chk(locked_o == 1'b0, "R1 lock cleared by reset", locked_o, 0);
    rst_n = 1'b1;
    run_period(2'b10, 0);
    chk(width_o == 8'd0, "R5 invalid pattern ignored at zero", width_o, 0);
    chk(locked_o == 1'b0, "R5 invalid pattern leaves lock", locked_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule